// File: doc/BRIEF.md
# Sector-Tagged Test Pattern Generator and Checker

This block produces a stream of wide test words for a storage write path and checks a returning read stream against the same sequence. Data is grouped into 512-byte sectors, which are sixteen 256-bit beats at the default width. The block can mark each sector with its own sector number in a leading header. Five pattern kinds are available: a rising dword count, its bitwise inverse, constant zeros, constant ones, and a pseudo-random sequence. The pseudo-random sequence comes from two look-ahead shift-register lanes, and both lanes are reseeded from the sector number at every sector.

A transfer begins with a one-cycle `start` pulse, which loads the pattern code and the first sector number. After that, each `adv` strobe (write side) or each `rd_valid` beat (read side) moves the sequence on by one beat. On the read side, each valid beat is compared with the word the block currently expects. The first mismatch raises a sticky fail flag and freezes a record of the expected word, the received word and the byte offset of the failing beat. Pacing and FIFO handling are left to the surrounding logic.

Top module: `sector_pattern_unit`

## Requirements
- R1: `pat_sel` is latched at `start`. The codes are 3'b000 count-up, 3'b001 count-down, 3'b010 all zeros, 3'b011 all ones and 3'b100 pseudo-random. Codes 3'b101 to 3'b111 give all-zero words with no header.
- R2: In the count-up, count-down and pseudo-random modes, beat 0 of every sector carries the sector number in its lowest two dwords. Dword 0 (bits 31:0) holds sector bits 31:0, and dword 1 (bits 63:32) holds sector bits 47:32 zero-extended.
- R3: The all-zero and all-one modes give constant words on every beat, including beat 0 of each sector, with no header.
- R4: In count-up mode, dword k (bits 32k+31:32k) of the n-th beat since `start` holds (8*n + k) mod 2^32. Count-down mode gives the bitwise NOT of that value.
- R5: The pseudo-random step takes a 32-bit value s to {s[30:0], s[30]^s[20]^s[0]}. Dwords 0-3 come from lane A and dwords 4-7 from lane B. Each lane gives four successive values per beat and continues from there on the next beat of the same sector.
- R6: At the start of a sector, with L the low 32 bits of the sector number, lane A is seeded with {L[15:0], ~L[15:0]} and lane B with {~L[31:16], L[31:16]}. The seed is the lane's first value in beat 0.
- R7: After the 16th beat of a sector, the sector number goes up by one (carrying across all 48 bits) and both lanes are reseeded from the new number.
- R8: The output word changes only on a cycle with `adv` or `rd_valid` high (one beat per such cycle) or on `start`. Otherwise it holds.
- R9: A `rd_valid` beat whose `rd_data` differs from the expected word sets `fail` on the following cycle. `fail` then stays high until the next `start`. Matching beats never set it.
- R10: The first mismatch records the expected word, the received word and the byte offset (32 times the beat count since `start`). Later mismatches leave these records unchanged.
- R11: `start` clears `fail` and all three records to zero and restarts the sequence at beat 0 of the new sector number. `start` takes priority over `adv` and `rd_valid` in the same cycle.
- R12: After reset, `fail` and the records are zero, and the block produces count-up beat 0 of sector 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a transfer |
| pat_sel | input | 3 | Pattern code, latched at start |
| start_sector | input | 48 | First sector number, latched at start |
| adv | input | 1 | Advance the write stream by one beat |
| rd_valid | input | 1 | A read beat is present on rd_data |
| rd_data | input | 256 | Read beat to be compared |
| wr_data | output | 256 | Current generated (expected) beat |
| fail | output | 1 | Sticky mismatch flag |
| fail_exp | output | 256 | Expected word at the first mismatch |
| fail_got | output | 256 | Received word at the first mismatch |
| fail_off | output | 37 | Byte offset of the first mismatching beat |

## Verification
Every pattern code, including an unassigned one, is run through a table of transfers that cross sector boundaries. This separates header placement from pattern content, and separates header modes from headerless ones. One start sector has its low 32 bits all ones, so the boundary increment must carry into the high header dword and the reseed must wrap to zero. This exposes errors in the carry and in the seed formula. A read sequence with matching beats, then a mismatch, then a match and a second mismatch shows the difference between a sticky flag and a level flag, and between a first-failure record and a last-failure record. Idle cycles and a restart show that the sequence holds without strobes and that all state is cleared.

// File: rtl/spu_pkg.sv
package spu_pkg;

   typedef enum logic [2:0] {
      PAT_INC  = 3'd0,
      PAT_DEC  = 3'd1,
      PAT_ZERO = 3'd2,
      PAT_ONE  = 3'd3,
      PAT_PRBS = 3'd4
   } pat_e;

   // one step of the 32-bit Fibonacci shift register
   function automatic logic [31:0] prbs_next(input logic [31:0] s);
      return {s[30:0], s[30] ^ s[20] ^ s[0]};
   endfunction

   // per-lane seed built from the low sector bits and their complement
   function automatic logic [31:0] lane_seed(input logic [31:0] lo, input bit odd);
      return odd ? {~lo[31:16], lo[31:16]} : {lo[15:0], ~lo[15:0]};
   endfunction

   // modes whose sectors open with a header
   function automatic logic has_header(input logic [2:0] m);
      return (m == PAT_INC) || (m == PAT_DEC) || (m == PAT_PRBS);
   endfunction

endpackage

// File: rtl/spu_seq.sv
module spu_seq #(
   parameter int ADDR_W = 48,
   parameter int CNT_W  = 32,
   parameter int BEATS  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              step,
   output logic [$clog2(BEATS)-1:0] beat_idx,
   output logic [CNT_W-1:0]  beat_cnt,
   output logic [ADDR_W-1:0] sector_addr,
   output logic              reseed,
   output logic [31:0]       seed_lo
);
   localparam int BEAT_W = $clog2(BEATS);
   localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

   logic              last_beat;
   logic [ADDR_W-1:0] next_addr;

   assign last_beat = (beat_idx == LAST);
   assign next_addr = sector_addr + ADDR_W'(1);
   assign reseed    = start | (step & last_beat);
   assign seed_lo   = start ? start_addr[31:0] : next_addr[31:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_idx    <= '0;
         beat_cnt    <= '0;
         sector_addr <= '0;
      end else if (start) begin
         beat_idx    <= '0;
         beat_cnt    <= '0;
         sector_addr <= start_addr;
      end else if (step) begin
         beat_cnt <= beat_cnt + CNT_W'(1);
         if (last_beat) begin
            beat_idx    <= '0;
            sector_addr <= next_addr;
         end else begin
            beat_idx <= beat_idx + BEAT_W'(1);
         end
      end
   end

endmodule

// File: rtl/spu_prbs_lane.sv
module spu_prbs_lane
   import spu_pkg::*;
#(
   parameter bit ODD   = 1'b0,
   parameter int STEPS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [31:0]         seed_lo,
   input  logic                step,
   output logic [STEPS*32-1:0] vals
);
   localparam logic [31:0] RST_SEED = lane_seed(32'h0, ODD);

   logic [31:0] state_q;
   logic [31:0] chain [STEPS];
   logic [31:0] after_beat;

   // look-ahead: STEPS successive values from one register per cycle
   always_comb begin
      chain[0] = state_q;
      for (int j = 1; j < STEPS; j++) begin
         chain[j] = prbs_next(chain[j-1]);
      end
      after_beat = prbs_next(chain[STEPS-1]);
   end

   for (genvar j = 0; j < STEPS; j++) begin : g_out
      assign vals[j*32 +: 32] = chain[j];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RST_SEED;
      end else if (load) begin
         state_q <= lane_seed(seed_lo, ODD);
      end else if (step) begin
         state_q <= after_beat;
      end
   end

endmodule

// File: rtl/spu_word.sv
module spu_word
   import spu_pkg::*;
#(
   parameter int WORD_W = 256,
   parameter int ADDR_W = 48
) (
   input  logic [2:0]                        mode,
   input  logic                              first,
   input  logic [31-$clog2(WORD_W/32):0]     cnt_lo,
   input  logic [ADDR_W-1:0]                 sector_addr,
   input  logic [WORD_W-1:0]                 prbs,
   output logic [WORD_W-1:0]                 word
);
   localparam int DWORDS = WORD_W / 32;
   localparam int SH     = $clog2(DWORDS);

   logic        hdr_on;
   logic [31:0] hdr [2];

   assign hdr_on = first & has_header(mode);
   assign hdr[0] = sector_addr[31:0];
   assign hdr[1] = {{(64-ADDR_W){1'b0}}, sector_addr[ADDR_W-1:32]};

   for (genvar k = 0; k < DWORDS; k++) begin : g_dw
      localparam logic [SH-1:0] KIDX = SH'(k);
      logic [31:0] inc_v;
      logic [31:0] pat_v;
      assign inc_v = {cnt_lo, KIDX};
      always_comb begin
         unique case (mode)
            PAT_INC:  pat_v = inc_v;
            PAT_DEC:  pat_v = ~inc_v;
            PAT_ONE:  pat_v = '1;
            PAT_PRBS: pat_v = prbs[k*32 +: 32];
            default:  pat_v = '0;
         endcase
      end
      if (k < 2) begin : g_hdr
         assign word[k*32 +: 32] = hdr_on ? hdr[k] : pat_v;
      end else begin : g_body
         assign word[k*32 +: 32] = pat_v;
      end
   end

endmodule

// File: rtl/spu_check.sv
module spu_check #(
   parameter int WORD_W = 256,
   parameter int OFF_W  = 37
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rd_valid,
   input  logic [WORD_W-1:0] rd_data,
   input  logic [WORD_W-1:0] exp_word,
   input  logic [OFF_W-1:0]  cur_off,
   output logic              fail,
   output logic [WORD_W-1:0] fail_exp,
   output logic [WORD_W-1:0] fail_got,
   output logic [OFF_W-1:0]  fail_off
);
   logic first_miss;

   assign first_miss = rd_valid & (rd_data != exp_word) & ~fail;

   always_ff @(posedge clk) begin
      if (!rst_n || start) begin
         fail     <= 1'b0;
         fail_exp <= '0;
         fail_got <= '0;
         fail_off <= '0;
      end else if (first_miss) begin
         fail     <= 1'b1;
         fail_exp <= exp_word;
         fail_got <= rd_data;
         fail_off <= cur_off;
      end
   end

endmodule

// File: rtl/sector_pattern_unit.sv
module sector_pattern_unit
   import spu_pkg::*;
#(
   parameter int WORD_W = 256,
   parameter int ADDR_W = 48,
   parameter int CNT_W  = 32,
   parameter int OFF_W  = CNT_W + $clog2(WORD_W / 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        pat_sel,
   input  logic [ADDR_W-1:0] start_sector,
   input  logic              adv,
   input  logic              rd_valid,
   input  logic [WORD_W-1:0] rd_data,
   output logic [WORD_W-1:0] wr_data,
   output logic              fail,
   output logic [WORD_W-1:0] fail_exp,
   output logic [WORD_W-1:0] fail_got,
   output logic [OFF_W-1:0]  fail_off
);
   localparam int SECTOR_BITS = 512 * 8;
   localparam int BEATS       = SECTOR_BITS / WORD_W;
   localparam int BEAT_W      = $clog2(BEATS);
   localparam int DWORDS      = WORD_W / 32;
   localparam int SH          = $clog2(DWORDS);
   localparam int LANE_STEPS  = DWORDS / 2;
   localparam int BYTE_SH     = $clog2(WORD_W / 8);

   if (WORD_W % 64 != 0 || WORD_W < 128 || SECTOR_BITS % WORD_W != 0 || BEATS < 2) begin : g_bad_w
      $error("WORD_W must be a multiple of 64, at least 128, and divide a sector");
   end
   if (ADDR_W <= 32 || ADDR_W > 64) begin : g_bad_a
      $error("ADDR_W must lie in 33..64");
   end
   if (CNT_W < 32 - SH) begin : g_bad_c
      $error("CNT_W too small for the dword counter");
   end
   if (OFF_W != CNT_W + BYTE_SH) begin : g_bad_o
      $error("OFF_W must equal CNT_W plus the beat byte shift");
   end

   logic [2:0]        mode_q;
   logic              step;
   logic [BEAT_W-1:0] beat_idx;
   logic [CNT_W-1:0]  beat_cnt;
   logic [ADDR_W-1:0] sector_addr;
   logic              reseed;
   logic [31:0]       seed_lo;
   logic [WORD_W-1:0] prbs;

   assign step = (adv | rd_valid) & ~start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= PAT_INC;
      end else if (start) begin
         mode_q <= pat_sel;
      end
   end

   spu_seq #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .BEATS  (BEATS)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .start_addr  (start_sector),
      .step        (step),
      .beat_idx    (beat_idx),
      .beat_cnt    (beat_cnt),
      .sector_addr (sector_addr),
      .reseed      (reseed),
      .seed_lo     (seed_lo)
   );

   for (genvar l = 0; l < 2; l++) begin : g_lane
      spu_prbs_lane #(
         .ODD   (l[0]),
         .STEPS (LANE_STEPS)
      ) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (reseed),
         .seed_lo (seed_lo),
         .step    (step),
         .vals    (prbs[l*(WORD_W/2) +: WORD_W/2])
      );
   end

   spu_word #(
      .WORD_W (WORD_W),
      .ADDR_W (ADDR_W)
   ) u_word (
      .mode        (mode_q),
      .first       (beat_idx == '0),
      .cnt_lo      (beat_cnt[31-SH:0]),
      .sector_addr (sector_addr),
      .prbs        (prbs),
      .word        (wr_data)
   );

   spu_check #(
      .WORD_W (WORD_W),
      .OFF_W  (OFF_W)
   ) u_check (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .rd_valid (rd_valid),
      .rd_data  (rd_data),
      .exp_word (wr_data),
      .cur_off  ({beat_cnt, {BYTE_SH{1'b0}}}),
      .fail     (fail),
      .fail_exp (fail_exp),
      .fail_got (fail_got),
      .fail_off (fail_off)
   );

endmodule

// File: rtl/sector_pattern_unit_sva.sv
module sector_pattern_unit_sva #(
   parameter int WORD_W = 256,
   parameter int OFF_W  = 37
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              adv,
   input logic              rd_valid,
   input logic [WORD_W-1:0] wr_data,
   input logic              fail,
   input logic [WORD_W-1:0] fail_exp,
   input logic [WORD_W-1:0] fail_got,
   input logic [OFF_W-1:0]  fail_off
);

   AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !adv && !rd_valid) |=> $stable(wr_data)); // R8

   AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !start) |=> fail); // R9

   AST_FAIL_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> $past(rd_valid)); // R9

   AST_RECORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !start) |=> ($stable(fail_exp) && $stable(fail_got) && $stable(fail_off))); // R10

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!fail && fail_off == '0 && fail_exp == '0 && fail_got == '0)); // R11

endmodule

bind sector_pattern_unit sector_pattern_unit_sva #(
   .WORD_W (WORD_W),
   .OFF_W  (OFF_W)
) u_sva (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .adv      (adv),
   .rd_valid (rd_valid),
   .wr_data  (wr_data),
   .fail     (fail),
   .fail_exp (fail_exp),
   .fail_got (fail_got),
   .fail_off (fail_off)
);

// File: tb/sector_pattern_unit_test.sv
module sector_pattern_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 6;
   localparam logic [2:0]  TV_MODE  [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd6};
   localparam logic [47:0] TV_ADDR  [NV] = '{48'h1234_5678_9ABC, 48'h0000_FFFF_FFFF,
                                            48'h0000_0000_0005, 48'h0000_0000_0007,
                                            48'h0000_FFFF_FFFF, 48'h0000_0000_0042};
   localparam int          TV_BEATS [NV] = '{20, 18, 18, 18, 34, 3};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [2:0]   pat_sel = '0;
   logic [47:0]  start_sector = '0;
   logic         adv = 1'b0;
   logic         rd_valid = 1'b0;
   logic [255:0] rd_data = '0;
   logic [255:0] wr_data, fail_exp, fail_got;
   logic         fail;
   logic [36:0]  fail_off;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sector_pattern_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .pat_sel(pat_sel),
      .start_sector(start_sector), .adv(adv), .rd_valid(rd_valid),
      .rd_data(rd_data), .wr_data(wr_data), .fail(fail),
      .fail_exp(fail_exp), .fail_got(fail_got), .fail_off(fail_off)
   );

   function automatic logic [31:0] m_step(input logic [31:0] s);
      logic fb;
      fb = s[30] ^ s[20] ^ s[0];
      return {s[30:0], fb};
   endfunction

   function automatic logic [31:0] m_seed(input logic [31:0] lo, input int lane);
      if (lane == 0) return {lo[15:0], ~lo[15:0]};
      return {~lo[31:16], lo[31:16]};
   endfunction

   function automatic logic [255:0] model(input logic [2:0] m, input logic [47:0] base, input int n);
      logic [255:0] w;
      logic [47:0]  sec;
      int           beat;
      sec  = base + 48'(n / 16);
      beat = n % 16;
      w    = '0;
      for (int k = 0; k < 8; k++) begin
         logic [31:0] v;
         logic [31:0] s;
         case (m)
            3'd0: v = 32'(n * 8 + k);
            3'd1: v = ~32'(n * 8 + k);
            3'd3: v = 32'hFFFF_FFFF;
            3'd4: begin
               s = m_seed(sec[31:0], k / 4);
               for (int i = 0; i < 4 * beat + (k % 4); i++) s = m_step(s);
               v = s;
            end
            default: v = 32'h0;
         endcase
         if (beat == 0 && (m == 3'd0 || m == 3'd1 || m == 3'd4)) begin
            if (k == 0) v = sec[31:0];
            if (k == 1) v = {16'h0, sec[47:32]};
         end
         w[k*32 +: 32] = v;
      end
      return w;
   endfunction

   task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_start(input logic [2:0] m, input logic [47:0] a);
      @(negedge clk);
      pat_sel = m; start_sector = a; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic do_adv();
      adv = 1'b1;
      @(negedge clk);
      adv = 1'b0;
   endtask

   task automatic do_read(input logic [255:0] d);
      rd_valid = 1'b1; rd_data = d;
      @(negedge clk);
      rd_valid = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run hung, actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [47:0] a;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R12 reset state
      chk("R12 fail", {255'h0, fail}, 256'h0);
      chk("R12 fail_exp", fail_exp, 256'h0);
      chk("R12 fail_off", {219'h0, fail_off}, 256'h0);
      chk("R12 wr_data", wr_data, model(3'd0, 48'h0, 0));

      // table walk over all pattern codes
      for (int t = 0; t < NV; t++) begin
         string tag;
         case (TV_MODE[t])
            3'd0, 3'd1: tag = "R4";
            3'd2, 3'd3: tag = "R3";
            3'd4:       tag = "R5";
            default:    tag = "R1";
         endcase
         do_start(TV_MODE[t], TV_ADDR[t]);
         for (int b = 0; b < TV_BEATS[t]; b++) begin
            chk(tag, wr_data, model(TV_MODE[t], TV_ADDR[t], b));
            if (b % 16 == 0 && (TV_MODE[t] <= 3'd1 || TV_MODE[t] == 3'd4)) begin
               a = TV_ADDR[t] + 48'(b / 16);
               chk("R2 header", {192'h0, wr_data[63:0]}, {192'h0, 16'h0, a});
            end
            if (b == 16) begin
               a = TV_ADDR[t] + 48'd1;
               chk("R7 next sector", {192'h0, wr_data[63:0]},
                   (TV_MODE[t] == 3'd2 || TV_MODE[t] == 3'd3) ? {192'h0, wr_data[63:0]} : {192'h0, 16'h0, a});
            end
            if (b == 0 && TV_MODE[t] == 3'd4) begin
               chk("R6 lane B seed", {224'h0, wr_data[159:128]},
                   {224'h0, ~TV_ADDR[t][31:16], TV_ADDR[t][31:16]});
               chk("R6 lane A third", {224'h0, wr_data[95:64]},
                   {224'h0, m_step(m_step({TV_ADDR[t][15:0], ~TV_ADDR[t][15:0]}))});
            end
            if (b == 16 && TV_MODE[t] == 3'd4)
               chk("R7 reseed", {224'h0, wr_data[159:128]}, {224'h0, 32'h0000_0000 ^ 32'hFFFF_0000});
            if (b < TV_BEATS[t] - 1) do_adv();
         end
      end

      // R8 hold without strobes
      do_start(3'd0, 48'h77);
      repeat (3) @(negedge clk);
      chk("R8 hold", wr_data, model(3'd0, 48'h77, 0));
      do_adv();
      chk("R8 one step", wr_data, model(3'd0, 48'h77, 1));

      // read path
      a = 48'h0000_1357_2468;
      do_start(3'd4, a);
      for (int b = 0; b < 3; b++) do_read(model(3'd4, a, b));
      chk("R9 matches keep clear", {255'h0, fail}, 256'h0);
      do_read(model(3'd4, a, 3) ^ 256'h1);
      chk("R9 mismatch sets", {255'h0, fail}, {255'h0, 1'b1});
      chk("R10 exp record", fail_exp, model(3'd4, a, 3));
      chk("R10 got record", fail_got, model(3'd4, a, 3) ^ 256'h1);
      chk("R10 offset", {219'h0, fail_off}, 256'd96);
      do_read(model(3'd4, a, 4));
      do_read(~model(3'd4, a, 5));
      chk("R9 sticky", {255'h0, fail}, {255'h0, 1'b1});
      chk("R10 exp kept", fail_exp, model(3'd4, a, 3));
      chk("R10 offset kept", {219'h0, fail_off}, 256'd96);
      chk("R8 reads advance", wr_data, model(3'd4, a, 6));

      // R11 restart clears, start beats a simultaneous advance
      adv = 1'b1;
      do_start(3'd1, 48'h9);
      adv = 1'b0;
      chk("R11 fail cleared", {255'h0, fail}, 256'h0);
      chk("R11 got cleared", fail_got, 256'h0);
      chk("R11 offset cleared", {219'h0, fail_off}, 256'h0);
      chk("R11 restart word", wr_data, model(3'd1, 48'h9, 0));

      done = 1'b1;
      summary();
      $finish;
   end

endmodule